// File: doc/BRIEF.md
# Multiplexed Bus Adapter Controller

This controller lets a processor with separate address and data buses work in a socket that expects one shared, time-multiplexed address/data bus. It samples the processor's transfer start, acknowledge, transfer-in-progress and read/write strobes on the bus clock. It also samples the bus request, grant and busy lines. From these it produces enables for the external address and data translators, the data translator direction, and a drive/sample control for the shared bidirectional control lines.

A transfer runs through four phases: address, guard, data, then back to idle. The guard phase lasts `GAP_CYCLES` bus clocks (at least 1, default 1). In that interval both translator groups are off, so the address and data drivers cannot contend. All outputs are registered, are reset to defined levels and never float. Control-line strobes are active low (0 = asserted). The read/write input is 1 for a read.

Top module: `muxed_bus_adapter`

## Requirements
- R1: While reset is asserted, addrEn, dataEn, dataToCpu and ctlDrive are all 0.
- R2: In idle, a clock edge that samples tsN=0, taN=1 and ctlDrive=1 raises addrEn for exactly one cycle, starting the cycle after that edge.
- R3: A transfer start is ignored while taN=0 or while ctlDrive=0. No enable rises and dataToCpu keeps its value.
- R4: After addrEn falls, both enables stay 0 for GAP_CYCLES cycles before dataEn rises. addrEn and dataEn are never 1 together.
- R5: dataEn stays 1 until an edge samples taN=0. It is 0 from the following cycle, and the controller is idle again.
- R6: dataToCpu takes the rwN value sampled at the accepting edge (1 = read, data toward the processor; 0 = write, toward the socket). It holds that value until the next accepted transfer.
- R7: If tipN is sampled 1 in the address, guard or data phase, the transfer is abandoned. Both enables are 0 from the next cycle, and dataEn does not rise for that transfer.
- R8: An edge sampling bgN=0 makes ctlDrive 1 (control lines driven outward) the next cycle.
- R9: An edge sampling brN=0 with bgN=1 makes ctlDrive 0 (control lines sampled) the next cycle.
- R10: With bgN=1 and brN=1, ctlDrive holds its value while bbN=0. It becomes 0 after an edge samples bbN=1 (bus released, pulled up).
- R11: No output is ever unknown after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tsN | input | 1 | Transfer start, active low |
| taN | input | 1 | Transfer acknowledge, active low |
| tipN | input | 1 | Transfer in progress, active low |
| rwN | input | 1 | 1 = read, 0 = write |
| brN | input | 1 | Bus request, active low |
| bgN | input | 1 | Bus grant, active low |
| bbN | input | 1 | Bus busy, active low, pulled up |
| addrEn | output | 1 | Address translator enable |
| dataEn | output | 1 | Data translator enable |
| dataToCpu | output | 1 | Data translator direction, 1 = toward processor |
| ctlDrive | output | 1 | 1 = drive bidirectional control lines, 0 = sample them |

## Verification
A wrong phase or guard count shows at the ports within one clock. addrEn would last more than one cycle, dataEn would rise too early or overlap addrEn, or dataEn would fail to drop on the cycle after acknowledge. A stale direction latch shows as a wrong dataToCpu during the data phase of the next transfer. A wrong ownership state shows the next cycle as ctlDrive disagreeing with grant, request or busy. It also shows as a transfer start that is wrongly accepted or ignored. A cycle-accurate bench model runs under random stimulus and is compared every cycle, so any of these faults is caught on the first cycle it appears.

// File: rtl/mux_adapter_pkg.sv
package mux_adapter_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_GAP  = 2'd2,
    PH_DATA = 2'd3
  } phase_t;

  typedef struct packed {
    logic addrOn;
    logic dataOn;
    logic latchDir;
  } strobe_t;
endpackage

// File: rtl/mux_phase_ctrl.sv
module mux_phase_ctrl
  import mux_adapter_pkg::*;
#(
  parameter int GAP_CYCLES = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    tsN,
  input  logic    taN,
  input  logic    tipN,
  input  logic    ownBus,
  output strobe_t strobes
);
  localparam int CNT_W = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES);
  localparam logic [CNT_W-1:0] GAP_LOAD = CNT_W'(GAP_CYCLES - 1);

  phase_t phase, phaseNext;
  logic [CNT_W-1:0] gapCnt, gapCntNext;
  logic accept;

  assign accept = (phase == PH_IDLE) && !tsN && taN && ownBus;

  always_comb begin
    phaseNext  = phase;
    gapCntNext = gapCnt;
    unique case (phase)
      PH_IDLE: if (accept) phaseNext = PH_ADDR;
      PH_ADDR: begin
        if (tipN) phaseNext = PH_IDLE;
        else begin
          phaseNext  = PH_GAP;
          gapCntNext = GAP_LOAD;
        end
      end
      PH_GAP: begin
        if (tipN) phaseNext = PH_IDLE;
        else if (gapCnt == '0) phaseNext = PH_DATA;
        else gapCntNext = gapCnt - 1'b1;
      end
      PH_DATA: if (tipN || !taN) phaseNext = PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      gapCnt <= '0;
    end else begin
      phase  <= phaseNext;
      gapCnt <= gapCntNext;
    end
  end

  assign strobes.addrOn   = (phaseNext == PH_ADDR);
  assign strobes.dataOn   = (phaseNext == PH_DATA);
  assign strobes.latchDir = accept;

  // R3: a start while acknowledged or while not owning the bus leaves the block idle
  p_start_ignored_r3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && (!taN || !ownBus)) |=> (phase == PH_IDLE));
  // R5: acknowledge in the data phase ends the transfer
  p_ack_ends_r5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DATA && !taN) |=> (phase == PH_IDLE));
  // R7: losing transfer-in-progress abandons the transfer
  p_abort_r7: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE && tipN) |=> (phase == PH_IDLE));
endmodule

// File: rtl/mux_bus_dp.sv
module mux_bus_dp
  import mux_adapter_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobes,
  input  logic    rwN,
  input  logic    brN,
  input  logic    bgN,
  input  logic    bbN,
  output logic    addrEn,
  output logic    dataEn,
  output logic    dataToCpu,
  output logic    ctlDrive
);
  logic ctlNext;

  always_comb begin
    if (!bgN)             ctlNext = 1'b1;
    else if (!brN || bbN) ctlNext = 1'b0;
    else                  ctlNext = ctlDrive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrEn    <= 1'b0;
      dataEn    <= 1'b0;
      dataToCpu <= 1'b0;
      ctlDrive  <= 1'b0;
    end else begin
      addrEn   <= strobes.addrOn;
      dataEn   <= strobes.dataOn;
      ctlDrive <= ctlNext;
      if (strobes.latchDir) dataToCpu <= rwN;
    end
  end

  // R2: the address enable lasts a single cycle
  p_addr_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    addrEn |=> !addrEn);
  // R4: the two driver groups never overlap
  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(addrEn && dataEn));
  // R4: the data enable never follows the address enable directly
  p_guard_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataEn) |-> !$past(addrEn));
  // R6: direction is steady through the data phase
  p_dir_steady_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dataEn && $past(dataEn)) |-> $stable(dataToCpu));
  // R8: grant makes the control lines driven
  p_grant_r8: assert property (@(posedge clk) disable iff (!rstN)
    !bgN |=> ctlDrive);
  // R9: request without grant turns the control lines to inputs
  p_request_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!brN && bgN) |=> !ctlDrive);
  // R11: every control output is at a defined level
  p_defined_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown({addrEn, dataEn, dataToCpu, ctlDrive}));
endmodule

// File: rtl/muxed_bus_adapter.sv
module muxed_bus_adapter
  import mux_adapter_pkg::*;
#(
  parameter int GAP_CYCLES = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic tsN,
  input  logic taN,
  input  logic tipN,
  input  logic rwN,
  input  logic brN,
  input  logic bgN,
  input  logic bbN,
  output logic addrEn,
  output logic dataEn,
  output logic dataToCpu,
  output logic ctlDrive
);
  strobe_t strobes;

  mux_phase_ctrl #(.GAP_CYCLES(GAP_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .tsN(tsN), .taN(taN), .tipN(tipN),
    .ownBus(ctlDrive), .strobes(strobes)
  );

  mux_bus_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rwN(rwN),
    .brN(brN), .bgN(bgN), .bbN(bbN),
    .addrEn(addrEn), .dataEn(dataEn), .dataToCpu(dataToCpu), .ctlDrive(ctlDrive)
  );
endmodule

// File: tb/muxed_bus_adapter_bench.sv
`timescale 1ns/1ps
module muxed_bus_adapter_bench;
  localparam int GAP = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tsN = 1'b1, taN = 1'b1, tipN = 1'b1, rwN = 1'b1;
  logic brN = 1'b1, bgN = 1'b1, bbN = 1'b1;
  logic addrEn, dataEn, dataToCpu, ctlDrive;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // bench model state: 0 idle, 1 address, 2 guard, 3 data
  int mPh = 0, mCnt = 0;
  logic mA = 0, mD = 0, mDir = 0, mCtl = 0;

  always #5 clk = ~clk;

  muxed_bus_adapter #(.GAP_CYCLES(GAP)) u_muxed_bus_adapter (
    .clk(clk), .rstN(rstN), .tsN(tsN), .taN(taN), .tipN(tipN), .rwN(rwN),
    .brN(brN), .bgN(bgN), .bbN(bbN),
    .addrEn(addrEn), .dataEn(dataEn), .dataToCpu(dataToCpu), .ctlDrive(ctlDrive)
  );

  function automatic logic nextCtl(logic cur, logic g, logic r, logic b);
    if (!g) return 1'b1;
    if (!r || b) return 1'b0;
    return cur;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPh = 0; mCnt = 0; mA = 0; mD = 0; mDir = 0; mCtl = 0;
    end else begin
      int np;
      np = mPh;
      case (mPh)
        0: if (!tsN && taN && mCtl) begin np = 1; mDir = rwN; end
        1: begin np = tipN ? 0 : 2; mCnt = GAP; end
        2: begin
          mCnt = mCnt - 1;
          if (tipN) np = 0; else if (mCnt == 0) np = 3;
        end
        default: if (tipN || !taN) np = 0;
      endcase
      mPh = np;
      mA = (np == 1);
      mD = (np == 3);
      mCtl = nextCtl(mCtl, bgN, brN, bbN);
    end
  end

  task automatic expect4(string tag, logic a, logic d, logic dir, logic c);
    compared++;
    if ({addrEn, dataEn, dataToCpu, ctlDrive} !== {a, d, dir, c}) begin
      mismatched++;
      $display("FAIL %s: got a=%b d=%b dir=%b ctl=%b expected a=%b d=%b dir=%b ctl=%b",
               tag, addrEn, dataEn, dataToCpu, ctlDrive, a, d, dir, c);
    end
  endtask

  task automatic cyc(logic ts, logic ta, logic tip, logic rw, logic br, logic bg, logic bb);
    tsN = ts; taN = ta; tipN = tip; rwN = rw; brN = br; bgN = bg; bbN = bb;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect4("R1 reset", 0, 0, 0, 0);
    rstN = 1'b1;
    // ts ta tip rw br bg bb
    cyc(1,1,1,1,1,0,1); expect4("R8 grant", 0,0,0,1);
    cyc(0,1,0,0,1,0,1); expect4("R2 write address", 1,0,0,1);
    cyc(1,1,0,0,1,0,1); expect4("R4 guard", 0,0,0,1);
    cyc(1,1,0,1,1,0,1); expect4("R4 data after guard", 0,1,0,1);
    cyc(1,1,0,1,1,0,1); expect4("R5 data held", 0,1,0,1);
    cyc(1,0,0,1,1,0,1); expect4("R5 ack ends", 0,0,0,1);
    cyc(0,1,0,1,1,0,1); expect4("R6 read address", 1,0,1,1);
    cyc(1,1,0,0,1,0,1); expect4("R2 single address", 0,0,1,1);
    cyc(1,1,0,0,1,0,1); expect4("R6 read data dir", 0,1,1,1);
    cyc(1,0,0,0,1,0,1); expect4("R5 read ends", 0,0,1,1);
    cyc(0,0,0,0,1,0,1); expect4("R3 start with ack", 0,0,1,1);
    cyc(1,1,1,1,1,0,1); expect4("R3 still idle", 0,0,1,1);
    cyc(0,1,0,0,1,0,1); expect4("R7 address", 1,0,0,1);
    cyc(1,1,1,1,1,0,1); expect4("R7 abort", 0,0,0,1);
    cyc(1,1,1,1,1,0,1); expect4("R7 no data", 0,0,0,1);
    cyc(1,1,1,1,1,1,0); expect4("R10 busy holds", 0,0,0,1);
    cyc(1,1,1,1,1,1,1); expect4("R10 release", 0,0,0,0);
    cyc(0,1,0,1,1,1,1); expect4("R3 not owner", 0,0,0,0);
    cyc(1,1,1,1,1,1,1); expect4("R3 not owner idle", 0,0,0,0);
    cyc(1,1,1,1,1,0,1); expect4("R8 regrant", 0,0,0,1);
    cyc(1,1,1,1,0,1,0); expect4("R9 request", 0,0,0,0);

    rstN = 1'b0;
    @(negedge clk);
    expect4("R1 second reset", 0, 0, 0, 0);
    rstN = 1'b1;
    begin
      int seed;
      seed = $urandom(32'h5A17);
      seed = 0;
      for (int i = 0; i < 4000; i++) begin
        logic ts, ta, tip, br, bg, bb, rw;
        ts  = ($urandom % 4) == 0 ? 1'b0 : 1'b1;
        ta  = ($urandom % 3) == 0 ? 1'b0 : 1'b1;
        tip = ($urandom % 10) == 0 ? 1'b1 : 1'b0;
        rw  = 1'($urandom);
        br  = ($urandom % 8) == 0 ? 1'b0 : 1'b1;
        bg  = ($urandom % 5) == 0 ? 1'b1 : 1'b0;
        bb  = 1'($urandom);
        cyc(ts, ta, tip, rw, br, bg, bb);
        expect4("R2/R4/R5/R6/R8 random vs model", mA, mD, mDir, mCtl);
      end
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule